// File: doc/BRIEF.md
# Link Acknowledge Error Monitor

This block sits beside the initiator of a chip-to-chip link and follows each transaction through its acknowledge phase. When a transaction is issued, the block records its address, data and kind and then waits for the acknowledge. It reports three kinds of fault. The first is an acknowledge that does not arrive before a programmable limit. The second is a pair of parity bits from the target that differ from the parity the initiator expects. The third is an error line raised by the target during the acknowledge.

Each fault sets sticky status flags and raises the error interrupt. A master error flag then blocks all further link traffic. While that flag is set, every new request is replaced by an IDLE command, and the recorded address and data stay as they were so that a handler can read them. Some faults also cancel the next request. This happens when the faulted transaction was the read phase of a read-modify-write or a non-blocking write. Software clears the flags by writing ones to a clear mask. Clearing the master flag reopens the link.

Top module: `link_ack_monitor`

## Requirements
- R1: When `txn_start` is high, the master error flag is clear and no transaction is outstanding, `link_go` is high in that same cycle. From the next cycle `busy` is high and `buf_addr`/`buf_data` hold the request's address and data.
- R2: The first cycle after issue is wait cycle 0. With T = `timeout_cfg`, an acknowledge is accepted in wait cycles 0 to T inclusive. If none has come by the end of wait cycle T, status bit 0 (ERR) and bit 1 (TO) are set and `busy` falls. With T = 0, only an acknowledge in wait cycle 0 avoids the fault.
- R3: If `ack_parity` differs from `exp_parity` when an acknowledge is accepted, status bits 0 (ERR) and 2 (PAR) are set, and bits 6:5 take the received `ack_parity`.
- R4: If `ack_terr` is high when an acknowledge is accepted, status bits 0 (ERR) and 3 (TERR) are set.
- R5: When parity mismatch and target error occur on the same acknowledge, all of the matching flags are set in the same cycle.
- R6: `irq` is high exactly while status bit 0 (ERR) is set.
- R7: While ERR is set, `txn_start` drives `idle_sub` high and `link_go` low. No transaction is issued, and `buf_addr`/`buf_data` stay unchanged.
- R8: Suppose a fault ends a transaction of kind 2 (non-blocking write) or kind 3 (read phase of read-modify-write). The first request after it is cancelled and status bit 4 (CNCL) is set. A fault on kind 0 (read) or kind 1 (blocking write) cancels nothing.
- R9: A cycle with `clr_we` high clears each status bit 4:0 whose `clr_mask` bit is one, and clearing bit 2 also zeroes bits 6:5. A flag that is set in the same cycle stays set. Clearing ERR reopens the link, and the next request is issued and recaptured.
- R10: An acknowledge, parity or target-error input seen while no transaction is outstanding changes no status bit.
- R11: After reset, status is zero, `irq` and `busy` are low, and the buffers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_start | input | 1 | Request to issue a transaction |
| txn_kind | input | 2 | 0 read, 1 blocking write, 2 non-blocking write, 3 read-modify-write read |
| txn_addr | input | AW | Request address |
| txn_data | input | DW | Request data |
| ack_valid | input | 1 | Acknowledge from the target |
| ack_parity | input | 2 | Parity bits received with the acknowledge |
| exp_parity | input | 2 | Parity computed by the initiator |
| ack_terr | input | 1 | Target error line |
| timeout_cfg | input | TW | Acknowledge wait limit in cycles |
| clr_we | input | 1 | Status clear strobe |
| clr_mask | input | 5 | Write-one-to-clear mask for status bits 4:0 |
| link_go | output | 1 | Request forwarded to the link |
| idle_sub | output | 1 | Request replaced by IDLE |
| busy | output | 1 | Transaction outstanding |
| irq | output | 1 | Error interrupt |
| status | output | 7 | Sticky flags and captured parity |
| buf_addr | output | AW | Captured address |
| buf_data | output | DW | Captured data |

## Verification
The assertions assume three things about the inputs. `txn_start` is not raised while `busy` is high. `ack_valid` lasts one cycle for each transaction. `exp_parity` is valid in the cycle the acknowledge arrives. The bench meets these by driving every input on the falling edge. It waits for each transaction to end before it starts another, and it pulses the acknowledge only once. The one exception is a late acknowledge that arrives after a timeout, which exercises R10.

// File: rtl/lam_pkg.sv
package lam_pkg;

    localparam int FLAG_N = 5;
    localparam int STAT_W = FLAG_N + 2;

    typedef enum logic [1:0] {
        K_RD     = 2'd0,
        K_WR     = 2'd1,
        K_WR_NB  = 2'd2,
        K_RMW_RD = 2'd3
    } kind_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_WAIT = 1'b1
    } phase_e;

    typedef struct packed {
        logic timeout;
        logic parity;
        logic target;
    } fault_t;

    typedef struct packed {
        logic [1:0] parv;
        logic       cncl;
        logic       terr;
        logic       par;
        logic       tmo;
        logic       err;
    } stat_t;

    function automatic logic any_fault(fault_t f);
        return f.timeout | f.parity | f.target;
    endfunction

    function automatic logic arms_cancel(kind_e k);
        return (k == K_WR_NB) || (k == K_RMW_RD);
    endfunction

endpackage

// File: rtl/lam_ack_timer.sv
module lam_ack_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          run,
    input  logic          ack,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    logic [TW-1:0] cnt_q;
    logic          at_limit;

    assign at_limit = (cnt_q == limit);
    assign expired  = run & ~ack & at_limit;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= '0;
        end else if (run && !at_limit) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/lam_fault_eval.sv
module lam_fault_eval
    import lam_pkg::*;
(
    input  logic       in_wait,
    input  logic       ack_valid,
    input  logic [1:0] ack_parity,
    input  logic [1:0] exp_parity,
    input  logic       ack_terr,
    input  logic       expired,
    output fault_t     fault,
    output logic       done
);
    logic taken;

    assign taken = in_wait & ack_valid;

    always_comb begin
        fault         = '0;
        fault.timeout = expired;
        fault.parity  = taken & (ack_parity != exp_parity);
        fault.target  = taken & ack_terr;
    end

    assign done = taken | expired;
endmodule

// File: rtl/lam_status_reg.sv
module lam_status_reg
    import lam_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rec,
    input  fault_t            fault,
    input  logic [1:0]        parv_in,
    input  logic              cncl_set,
    input  logic              clr_we,
    input  logic [FLAG_N-1:0] clr_mask,
    output stat_t             stat
);
    logic [FLAG_N-1:0] flags_q;
    logic [FLAG_N-1:0] set_v;
    logic [FLAG_N-1:0] clr_v;
    logic [1:0]        parv_q;

    always_comb begin
        set_v    = '0;
        set_v[0] = rec & any_fault(fault);
        set_v[1] = rec & fault.timeout;
        set_v[2] = rec & fault.parity;
        set_v[3] = rec & fault.target;
        set_v[4] = cncl_set;
        clr_v    = clr_we ? clr_mask : '0;
    end

    for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                flags_q[i] <= 1'b0;
            end else begin
                flags_q[i] <= (flags_q[i] & ~clr_v[i]) | set_v[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            parv_q <= '0;
        end else if (set_v[2]) begin
            parv_q <= parv_in;
        end else if (clr_v[2]) begin
            parv_q <= '0;
        end
    end

    always_comb begin
        stat      = '0;
        stat.err  = flags_q[0];
        stat.tmo  = flags_q[1];
        stat.par  = flags_q[2];
        stat.terr = flags_q[3];
        stat.cncl = flags_q[4];
        stat.parv = parv_q;
    end
endmodule

// File: rtl/link_ack_monitor.sv
module link_ack_monitor
    import lam_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int TW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              txn_start,
    input  logic [1:0]        txn_kind,
    input  logic [AW-1:0]     txn_addr,
    input  logic [DW-1:0]     txn_data,
    input  logic              ack_valid,
    input  logic [1:0]        ack_parity,
    input  logic [1:0]        exp_parity,
    input  logic              ack_terr,
    input  logic [TW-1:0]     timeout_cfg,
    input  logic              clr_we,
    input  logic [FLAG_N-1:0] clr_mask,
    output logic              link_go,
    output logic              idle_sub,
    output logic              busy,
    output logic              irq,
    output logic [STAT_W-1:0] status,
    output logic [AW-1:0]     buf_addr,
    output logic [DW-1:0]     buf_data
);
    phase_e        phase_q;
    kind_e         kind_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic          pend_q;
    logic          expired;
    logic          done;
    logic          rec;
    logic          cncl_set;
    logic          err_clr;
    fault_t        fault;
    stat_t         stat;

    assign busy     = (phase_q == S_WAIT);
    assign link_go  = txn_start & ~stat.err & ~busy;
    assign idle_sub = txn_start & stat.err;
    assign rec      = done & any_fault(fault);
    assign cncl_set = idle_sub & pend_q;
    assign err_clr  = clr_we & clr_mask[0] & ~rec;

    lam_ack_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .start   (link_go),
        .run     (busy),
        .ack     (ack_valid),
        .limit   (timeout_cfg),
        .expired (expired)
    );

    lam_fault_eval u_eval (
        .in_wait    (busy),
        .ack_valid  (ack_valid),
        .ack_parity (ack_parity),
        .exp_parity (exp_parity),
        .ack_terr   (ack_terr),
        .expired    (expired),
        .fault      (fault),
        .done       (done)
    );

    lam_status_reg u_stat (
        .clk      (clk),
        .rst      (rst),
        .rec      (rec),
        .fault    (fault),
        .parv_in  (ack_parity),
        .cncl_set (cncl_set),
        .clr_we   (clr_we),
        .clr_mask (clr_mask),
        .stat     (stat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= S_IDLE;
        end else if (link_go) begin
            phase_q <= S_WAIT;
        end else if (done) begin
            phase_q <= S_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q <= K_RD;
            addr_q <= '0;
            data_q <= '0;
        end else if (link_go) begin
            kind_q <= kind_e'(txn_kind);
            addr_q <= txn_addr;
            data_q <= txn_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
        end else if (rec) begin
            pend_q <= arms_cancel(kind_q);
        end else if (err_clr || cncl_set) begin
            pend_q <= 1'b0;
        end
    end

    assign irq      = stat.err;
    assign status   = stat;
    assign buf_addr = addr_q;
    assign buf_data = data_q;
endmodule

// File: rtl/link_ack_monitor_chk.sv
module link_ack_monitor_chk #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          txn_start,
    input logic          ack_valid,
    input logic [1:0]    ack_parity,
    input logic [1:0]    exp_parity,
    input logic          link_go,
    input logic          idle_sub,
    input logic          busy,
    input logic          irq,
    input logic [6:0]    status,
    input logic [AW-1:0] buf_addr,
    input logic [DW-1:0] buf_data
);
    p_go_busy_r1: assert property (@(posedge clk) disable iff (rst)
        link_go |=> busy);

    p_timeout_cause_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(status[1]) |-> ($past(busy) && !$past(ack_valid)));

    p_parity_cause_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(status[2]) |-> ($past(ack_valid) && ($past(ack_parity) != $past(exp_parity))));

    p_irq_from_txn_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(busy));

    p_blocked_r7: assert property (@(posedge clk) disable iff (rst)
        irq |-> !link_go);

    p_substitute_r7: assert property (@(posedge clk) disable iff (rst)
        (txn_start && irq) |-> idle_sub);

    p_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        (irq && $past(irq)) |-> ($stable(buf_addr) && $stable(buf_data)));

    p_cancel_cause_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(status[4]) |-> ($past(txn_start) && $past(irq)));
endmodule

bind link_ack_monitor link_ack_monitor_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .txn_start  (txn_start),
    .ack_valid  (ack_valid),
    .ack_parity (ack_parity),
    .exp_parity (exp_parity),
    .link_go    (link_go),
    .idle_sub   (idle_sub),
    .busy       (busy),
    .irq        (irq),
    .status     (status),
    .buf_addr   (buf_addr),
    .buf_data   (buf_data)
);

// File: tb/link_ack_monitor_bench.sv
`timescale 1ns/1ps
module link_ack_monitor_bench;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int TW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          txn_start = 1'b0;
    logic [1:0]    txn_kind = '0;
    logic [AW-1:0] txn_addr = '0;
    logic [DW-1:0] txn_data = '0;
    logic          ack_valid = 1'b0;
    logic [1:0]    ack_parity = '0;
    logic [1:0]    exp_parity = '0;
    logic          ack_terr = 1'b0;
    logic [TW-1:0] timeout_cfg = '0;
    logic          clr_we = 1'b0;
    logic [4:0]    clr_mask = '0;
    logic          link_go, idle_sub, busy, irq;
    logic [6:0]    status;
    logic [AW-1:0] buf_addr;
    logic [DW-1:0] buf_data;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    link_ack_monitor #(.AW(AW), .DW(DW), .TW(TW)) u_link_ack_monitor (
        .clk(clk), .rst(rst), .txn_start(txn_start), .txn_kind(txn_kind),
        .txn_addr(txn_addr), .txn_data(txn_data), .ack_valid(ack_valid),
        .ack_parity(ack_parity), .exp_parity(exp_parity), .ack_terr(ack_terr),
        .timeout_cfg(timeout_cfg), .clr_we(clr_we), .clr_mask(clr_mask),
        .link_go(link_go), .idle_sub(idle_sub), .busy(busy), .irq(irq),
        .status(status), .buf_addr(buf_addr), .buf_data(buf_data)
    );

    typedef struct packed {
        logic [1:0] kind;
        logic [7:0] tmo;
        logic [7:0] dly;
        logic       ack;
        logic [1:0] pexp;
        logic [1:0] prx;
        logic       terr;
        logic [6:0] expst;
    } vec_t;

    // status: bit0 ERR, bit1 TO, bit2 PAR, bit3 TERR, bit4 CNCL, bits6:5 received parity
    localparam vec_t VECS [9] = '{
        '{2'd0, 8'd5, 8'd2, 1'b1, 2'b01, 2'b01, 1'b0, 7'h00}, // R1 clean
        '{2'd0, 8'd5, 8'd1, 1'b1, 2'b01, 2'b10, 1'b0, 7'h45}, // R3 parity
        '{2'd1, 8'd5, 8'd3, 1'b1, 2'b00, 2'b00, 1'b1, 7'h09}, // R4 target error
        '{2'd0, 8'd6, 8'd0, 1'b1, 2'b00, 2'b11, 1'b1, 7'h6D}, // R5 both
        '{2'd0, 8'd3, 8'd0, 1'b0, 2'b00, 2'b00, 1'b0, 7'h03}, // R2 no ack
        '{2'd1, 8'd0, 8'd0, 1'b0, 2'b00, 2'b00, 1'b0, 7'h03}, // R2 zero limit
        '{2'd0, 8'd0, 8'd0, 1'b1, 2'b10, 2'b10, 1'b0, 7'h00}, // R2 zero limit, ack in time
        '{2'd0, 8'd4, 8'd4, 1'b1, 2'b11, 2'b11, 1'b0, 7'h00}, // R2 ack on last cycle
        '{2'd0, 8'd4, 8'd5, 1'b1, 2'b00, 2'b01, 1'b1, 7'h03}  // R2 late, R10 stray ack ignored
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    function automatic string tag_of(input logic [6:0] st);
        if (st == 7'h00) return "R1";
        if (st[2] && st[3]) return "R5";
        if (st[2]) return "R3";
        if (st[3]) return "R4";
        return "R2";
    endfunction

    task automatic run_txn(input logic [1:0] kind, input logic [15:0] addr, input logic [15:0] data,
                           input logic [7:0] tmo, input logic [7:0] dly, input logic do_ack,
                           input logic [1:0] pexp, input logic [1:0] prx, input logic terr);
        timeout_cfg = tmo;
        txn_kind    = kind;
        txn_addr    = addr;
        txn_data    = data;
        txn_start   = 1'b1;
        step();
        txn_start = 1'b0;
        if (do_ack) begin
            for (int i = 0; i < int'(dly); i++) step();
            ack_valid  = 1'b1;
            exp_parity = pexp;
            ack_parity = prx;
            ack_terr   = terr;
            step();
            ack_valid = 1'b0;
            ack_terr  = 1'b0;
        end else begin
            for (int i = 0; i < int'(tmo) + 3; i++) step();
        end
        step();
    endtask

    task automatic clear(input logic [4:0] m);
        clr_we   = 1'b1;
        clr_mask = m;
        step();
        clr_we   = 1'b0;
        clr_mask = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        // R11 reset state
        check("R11 status", status, 0);
        check("R11 irq", irq, 0);
        check("R11 busy", busy, 0);
        check("R11 buf_addr", buf_addr, 0);

        // R1 issue
        timeout_cfg = 8'd5;
        txn_kind = 2'd0; txn_addr = 16'h1234; txn_data = 16'hBEEF;
        txn_start = 1'b1;
        #1 check("R1 link_go", link_go, 1);
        step();
        txn_start = 1'b0;
        check("R1 busy", busy, 1);
        check("R1 buf_addr", buf_addr, 16'h1234);
        check("R1 buf_data", buf_data, 16'hBEEF);
        ack_valid = 1'b1; exp_parity = 2'b00; ack_parity = 2'b00;
        step();
        ack_valid = 1'b0;
        check("R1 clean status", status, 0);
        check("R1 idle after ack", busy, 0);

        // vector walk (R2 R3 R4 R5 R6 R9 R10)
        for (int v = 0; v < 9; v++) begin
            run_txn(VECS[v].kind, 16'h0100 + 16'(v), 16'hA000 + 16'(v), VECS[v].tmo, VECS[v].dly,
                    VECS[v].ack, VECS[v].pexp, VECS[v].prx, VECS[v].terr);
            check(tag_of(VECS[v].expst), status, VECS[v].expst);
            check("R6 irq", irq, VECS[v].expst[0]);
            clear(5'h1F);
            check("R9 clear all", status, 0);
        end

        // R7 substitution and freeze, R8 no cancel after blocking write
        run_txn(2'd1, 16'h0A01, 16'h1111, 8'd5, 8'd1, 1'b1, 2'b00, 2'b01, 1'b0);
        check("R3 parity flag", status, 7'h25);
        txn_addr = 16'h0A02; txn_data = 16'h2222; txn_start = 1'b1;
        #1 check("R7 idle_sub", idle_sub, 1);
        check("R7 link_go", link_go, 0);
        step();
        txn_start = 1'b0;
        check("R7 no busy", busy, 0);
        check("R7 frozen addr", buf_addr, 16'h0A01);
        check("R7 frozen data", buf_data, 16'h1111);
        check("R8 no cancel on blocking write", status[4], 0);

        // R9 partial clear, then release
        clear(5'h01);
        check("R9 ERR cleared PAR kept", status, 7'h24);
        check("R6 irq low", irq, 0);
        txn_addr = 16'h0A03; txn_data = 16'h3333; txn_start = 1'b1;
        #1 check("R9 link reopened", link_go, 1);
        step();
        txn_start = 1'b0;
        check("R9 recapture", buf_addr, 16'h0A03);
        ack_valid = 1'b1; exp_parity = 2'b00; ack_parity = 2'b00;
        step();
        ack_valid = 1'b0;
        clear(5'h04);
        check("R9 PAR clear zeroes parity field", status, 0);

        // R8 cancel after non-blocking write timeout
        run_txn(2'd2, 16'h0B00, 16'h4444, 8'd1, 8'd0, 1'b0, 2'b00, 2'b00, 1'b0);
        check("R2 nb timeout", status, 7'h03);
        txn_start = 1'b1; step(); txn_start = 1'b0;
        check("R8 cancel nb write", status, 7'h13);
        clear(5'h1F);

        // R8 cancel after read-modify-write read target error
        run_txn(2'd3, 16'h0C00, 16'h5555, 8'd4, 8'd2, 1'b1, 2'b00, 2'b00, 1'b1);
        check("R4 rmw target error", status, 7'h09);
        txn_start = 1'b1; step(); txn_start = 1'b0;
        check("R8 cancel rmw", status, 7'h19);

        // R11 reset clears a faulted state
        rst = 1'b1; step(); rst = 1'b0; step();
        check("R11 reset after fault", status, 0);
        check("R11 buf after reset", buf_addr, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule